// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running calendar time and decides, once per second, whether a programmed alarm is due. On the cycle that carries the 1 Hz update strobe, it compares five packed BCD time fields (seconds, minutes, hours, day of month, month) with five programmed alarm bytes. The current-time inputs must already hold the advanced count on that cycle. Each field has an ignore bit. A field whose ignore bit is 1 plays no part in the result. A field whose ignore bit is 0 must be equal. The ignore bits therefore set how often the alarm fires. With every field ignored it fires each second. If only the seconds field is compared it fires each minute. Comparing seconds and minutes gives one alarm per hour, adding hours gives one per day, and adding the day gives one per month.

A hit raises a one-cycle pulse and sets a sticky flag. The flag stays set until the clear input is asserted. The flag is held by a two-state machine. FLAG_LOW is the reset state. The transition T_SET moves it to FLAG_HIGH on a hit. FLAG_HIGH stays put through T_HOLD. The transition T_CLEAR returns it to FLAG_LOW when the clear input is high and no hit happens in the same cycle. T_RESET forces FLAG_LOW from either state whenever reset is low. Before comparison, each byte has the bits above its field's BCD width forced to zero. Those widths are 7 bits for seconds and minutes, 6 for hours and day, and 5 for month.

Top module: `alm_match_top`

## Requirements
- R1: `alm_ignore` bit positions are bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day, bit 4 month. With all five bits at 1, every tick produces an alarm.
- R2: A field whose ignore bit is 0 must equal its alarm byte, otherwise the tick produces no alarm.
- R3: A hit is only taken on a cycle where `tick_1hz` is 1. Matching fields without a tick give no pulse and do not set the flag.
- R4: `alarm_pulse` is 1 exactly in the cycle after the clock edge that sampled the qualifying tick, and is 0 in the following cycle unless another hit is sampled.
- R5: `alarm_flag` becomes 1 together with the pulse. It holds while `flag_clr` is 0 and falls one cycle after `flag_clr` is sampled without a hit.
- R6: When `flag_clr` and a hit are sampled in the same cycle, the flag stays 1.
- R7: Bits above each field's width are ignored in the comparison. The ignored bits are seconds bit 7, minutes bit 7, hours bits 7:6, day bits 7:6, and month bits 7:5.
- R8: While `rst_n` is 0, `alarm_flag` and `alarm_pulse` are 0 whatever the other inputs are.
- R9: Over a continuously advancing clock, the ignore settings 1Fh, 1Eh and 1Ch give one alarm per second, per minute and per hour, and no pulse comes on a non-matching tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second, after the time has advanced |
| flag_clr | input | 1 | Clears the sticky alarm flag |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_month | input | 8 | Current month, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_hour | input | 8 | Alarm hours, BCD |
| alm_date | input | 8 | Alarm day of month, BCD |
| alm_month | input | 8 | Alarm month, BCD |
| alm_ignore | input | 5 | Per-field ignore bits (1 = field excluded) |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_pulse | output | 1 | One-cycle alarm pulse |

## Verification
Both results are registered. The pulse and the flag change in the cycle after the rising edge that samples a tick or a clear, and nothing is due earlier. The bench changes inputs on the falling edge and holds them through exactly one rising edge. It reads the outputs at the next falling edge, so every check looks at the state that the single sampled edge produced. The check one further falling edge later confirms that the pulse has dropped while the flag holds.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int NUM_FIELDS = 5;
    localparam int BYTE_W     = 8;
    // used BCD width per field: seconds, minutes, hours, day, month
    localparam int FIELD_BITS [NUM_FIELDS] = '{7, 7, 6, 6, 5};

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_vec_t;

    typedef enum logic [0:0] {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int BYTE_W = 8,
    parameter int USED_W = 7
) (
    input  logic [BYTE_W-1:0] now_val,
    input  logic [BYTE_W-1:0] set_val,
    input  logic              skip,
    output logic              agree
);
    localparam logic [BYTE_W-1:0] KEEP = BYTE_W'((1 << USED_W) - 1);

    logic [BYTE_W-1:0] now_clean;
    logic [BYTE_W-1:0] set_clean;

    always_comb begin
        now_clean = now_val & KEEP;
        set_clean = set_val & KEEP;
        agree     = skip | (now_clean == set_clean);
    end
endmodule

// File: rtl/alm_match_tree.sv
module alm_match_tree
    import alm_pkg::*;
(
    input  field_vec_t            now_fields,
    input  field_vec_t            set_fields,
    input  logic [NUM_FIELDS-1:0] skip,
    output logic                  all_agree
);
    logic [NUM_FIELDS-1:0] agree_bits;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        alm_field_cmp #(
            .BYTE_W (BYTE_W),
            .USED_W (FIELD_BITS[i])
        ) cmp_i (
            .now_val (now_fields[i]),
            .set_val (set_fields[i]),
            .skip    (skip[i]),
            .agree   (agree_bits[i])
        );
    end

    assign all_agree = &agree_bits;
endmodule

// File: rtl/alm_flag_fsm.sv
module alm_flag_fsm
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag,
    output logic pulse
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW:  if (hit)         state_d = FLAG_HIGH; // T_SET
            FLAG_HIGH: if (clr && !hit) state_d = FLAG_LOW;  // T_CLEAR, else T_HOLD
            default:                    state_d = FLAG_LOW;
        endcase
    end

    // state register (T_RESET)
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= hit;
    end

    assign flag = (state_q == FLAG_HIGH);
endmodule

// File: rtl/alm_match_top.sv
module alm_match_top
    import alm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1hz,
    input  logic                  flag_clr,
    input  logic [BYTE_W-1:0]     cur_sec,
    input  logic [BYTE_W-1:0]     cur_min,
    input  logic [BYTE_W-1:0]     cur_hour,
    input  logic [BYTE_W-1:0]     cur_date,
    input  logic [BYTE_W-1:0]     cur_month,
    input  logic [BYTE_W-1:0]     alm_sec,
    input  logic [BYTE_W-1:0]     alm_min,
    input  logic [BYTE_W-1:0]     alm_hour,
    input  logic [BYTE_W-1:0]     alm_date,
    input  logic [BYTE_W-1:0]     alm_month,
    input  logic [NUM_FIELDS-1:0] alm_ignore,
    output logic                  alarm_flag,
    output logic                  alarm_pulse
);
    field_vec_t now_fields;
    field_vec_t set_fields;
    logic       all_agree;
    logic       hit;

    assign now_fields = {cur_month, cur_date, cur_hour, cur_min, cur_sec};
    assign set_fields = {alm_month, alm_date, alm_hour, alm_min, alm_sec};

    alm_match_tree tree_i (
        .now_fields (now_fields),
        .set_fields (set_fields),
        .skip       (alm_ignore),
        .all_agree  (all_agree)
    );

    assign hit = tick_1hz & all_agree;

    alm_flag_fsm fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (flag_clr),
        .flag  (alarm_flag),
        .pulse (alarm_pulse)
    );
endmodule

// File: rtl/alm_match_chk.sv
module alm_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       flag_clr,
    input logic [4:0] alm_ignore,
    input logic       alarm_flag,
    input logic       alarm_pulse
);
    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> $past(tick_1hz)); // R3
    AST_NO_TICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz |=> !alarm_pulse); // R4
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> alarm_flag); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clr) |=> alarm_flag); // R5
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !tick_1hz) |=> !alarm_flag); // R5
    AST_FLAG_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> alarm_pulse); // R5
    AST_ALL_IGNORED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && alm_ignore == 5'h1f) |=> (alarm_pulse && alarm_flag)); // R1 R6
endmodule

bind alm_match_top alm_match_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1hz    (tick_1hz),
    .flag_clr    (flag_clr),
    .alm_ignore  (alm_ignore),
    .alarm_flag  (alarm_flag),
    .alarm_pulse (alarm_pulse)
);

// File: tb/alm_match_top_tb_top.sv
`timescale 1ns/1ps
module alm_match_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_month = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0, alm_date = '0, alm_month = '0;
    logic [4:0] alm_ignore = '0;
    logic       alarm_flag;
    logic       alarm_pulse;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    alm_match_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .flag_clr(flag_clr),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_date(alm_date), .alm_month(alm_month),
        .alm_ignore(alm_ignore),
        .alarm_flag(alarm_flag), .alarm_pulse(alarm_pulse)
    );

    // {ignore[4:0], current {mon,date,hour,min,sec}, alarm {mon,date,hour,min,sec}, expected}
    localparam int NV = 12;
    localparam logic [85:0] VEC [NV] = '{
        {5'h1f, 40'h12_31_23_59_59, 40'h00_00_00_00_00, 1'b1}, // R1
        {5'h1e, 40'h01_01_00_00_30, 40'h05_05_05_05_30, 1'b1}, // R2 seconds only
        {5'h1e, 40'h01_01_00_00_31, 40'h05_05_05_05_30, 1'b0}, // R2
        {5'h1c, 40'h01_01_00_42_30, 40'h09_09_09_42_30, 1'b1}, // R2
        {5'h1c, 40'h01_01_00_43_30, 40'h09_09_09_42_30, 1'b0}, // R2
        {5'h00, 40'h11_28_17_05_09, 40'h11_28_17_05_09, 1'b1}, // R2 all fields
        {5'h00, 40'h10_28_17_05_09, 40'h11_28_17_05_09, 1'b0}, // R2 month differs
        {5'h1e, 40'h00_00_00_00_B0, 40'h00_00_00_00_30, 1'b1}, // R7 seconds bit 7
        {5'h1b, 40'h00_00_D2_00_00, 40'h00_00_12_00_00, 1'b1}, // R7 hours bits 7:6
        {5'h0f, 40'hE9_00_00_00_00, 40'h09_00_00_00_00, 1'b1}, // R7 month bits 7:5
        {5'h1d, 40'h00_00_00_45_00, 40'h00_00_00_44_00, 1'b0}, // R2 minutes only
        {5'h1e, 40'h00_00_00_00_B0, 40'h00_00_00_00_31, 1'b0}  // R7 low bits still count
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive for one rising edge, return at the falling edge after it
    task automatic step(input logic t, input logic c);
        tick_1hz = t;
        flag_clr = c;
        @(negedge clk);
        tick_1hz = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic load(input logic [4:0] ig, input logic [39:0] cur, input logic [39:0] alm);
        alm_ignore = ig;
        {cur_month, cur_date, cur_hour, cur_min, cur_sec} = cur;
        {alm_month, alm_date, alm_hour, alm_min, alm_sec} = alm;
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    // R9: run an advancing clock starting at 00:58:00 and count alarms
    task automatic run_span(input logic [4:0] ig, input int a_min, input int a_sec,
                            input int exp_total, input string tag);
        int s = 0, m = 58, h = 0, bad = 0, seen = 0;
        alm_ignore = ig;
        alm_sec = to_bcd(a_sec); alm_min = to_bcd(a_min);
        alm_hour = 8'h07; alm_date = 8'h03; alm_month = 8'h04;
        cur_date = 8'h15; cur_month = 8'h06;
        for (int n = 0; n < 3720; n++) begin
            bit want;
            cur_sec = to_bcd(s); cur_min = to_bcd(m); cur_hour = to_bcd(h);
            want = (ig[0] || s == a_sec) && (ig[1] || m == a_min);
            step(1'b1, 1'b0);
            if (alarm_pulse !== want) bad++;
            if (alarm_pulse === 1'b1) seen++;
            s++;
            if (s == 60) begin s = 0; m++; end
            if (m == 60) begin m = 0; h++; end
        end
        check("R9", bad, 0, {tag, " ticks with wrong pulse"});
        check("R9", seen, exp_total, {tag, " pulse count"});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        // R8: reset holds outputs low even with a qualifying tick
        load(5'h1f, 40'h0, 40'h0);
        @(negedge clk);
        step(1'b1, 1'b0);
        check("R8", alarm_pulse, 0, "pulse in reset");
        check("R8", alarm_flag, 0, "flag in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R4 R7
        for (int i = 0; i < NV; i++) begin
            logic [85:0] v;
            v = VEC[i];
            load(v[85:81], v[80:41], v[40:1]);
            step(1'b0, 1'b1);
            step(1'b1, 1'b0);
            check("R1/R2/R7", alarm_pulse, v[0], $sformatf("vector %0d pulse", i));
            check("R5", alarm_flag, v[0], $sformatf("vector %0d flag", i));
            @(negedge clk);
            check("R4", alarm_pulse, 0, $sformatf("vector %0d pulse drop", i));
        end

        // R3: matching fields, no tick
        load(5'h00, 40'h02_14_08_30_45, 40'h02_14_08_30_45);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R3", alarm_pulse, 0, "pulse without tick");
        check("R3", alarm_flag, 0, "flag without tick");

        // R5: flag holds, then clears
        step(1'b1, 1'b0);
        check("R4", alarm_pulse, 1, "pulse after tick edge");
        repeat (5) step(1'b0, 1'b0);
        check("R5", alarm_flag, 1, "flag holds");
        check("R4", alarm_pulse, 0, "pulse single cycle");
        step(1'b0, 1'b1);
        check("R5", alarm_flag, 0, "flag cleared");

        // R6: clear and hit together
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R6", alarm_flag, 1, "set wins over clear");
        check("R6", alarm_pulse, 1, "pulse with clear");
        step(1'b0, 1'b1);
        check("R6", alarm_flag, 0, "later clear");

        // R9: rates over 62 minutes from 00:58:00
        run_span(5'h1f, 0, 0, 3720, "per second");
        run_span(5'h1e, 0, 10, 62, "per minute");
        run_span(5'h1c, 59, 10, 2, "per hour");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule